// File: doc/BRIEF.md
# Byte-Serial Transmitter with Hang-Bit Idle Detection

This block turns bytes written by a host into a serial bit stream. It sends one bit for each pulse of a bit-rate enable, most significant bit first. A single holding buffer sits in front of a shift register. When the shift register takes the buffered byte, the block raises a data-ready request so the host can supply the next byte, and consecutive bytes leave with no gap between them.

When the stream runs dry, the transmitter spends one extra bit period on a hang bit at the level of the last data bit. It then raises an idle flag. Each of the two flags has its own clear rules, tied to host writes, status reads and the receive/transmit mode bit. The interrupt output is the OR of the two flags.

Top module: `byte_serial_tx`

## Requirements
- R1: While `tx_mode` is 1, every `bit_en` pulse that finds a byte in progress drives its next bit onto `ser_out`. Bit 7 goes first and bit 0 last, and a buffered byte follows the previous one with no gap.
- R2: The buffered byte moves into the shift register on the `bit_en` pulse that follows the last bit of the previous byte. If the shift register is already empty, it moves on the first `bit_en` pulse after the write. Its bit 7 appears on `ser_out` and `rdy_flag` becomes 1 at that same edge.
- R3: `rdy_flag` clears only on a `wr_en` that comes after at least one `stat_rd` pulse seen while `rdy_flag` was 1. A write without such a read leaves it set. A write in the same cycle as a load leaves it set.
- R4: After the last data bit, the next `bit_en` pulse starts a hang bit and `ser_out` keeps the last data bit's level. The following `bit_en` pulse, if no byte is waiting, sets `idle_flag`. `ser_out` then holds its level.
- R5: A `wr_en` while `tx_mode` is 1 clears `idle_flag`, and it keeps the flag clear even in the cycle where the hang bit ends. The written byte is then sent.
- R6: While `tx_mode` is 0, both flags are 0, the buffer and shift register are emptied, writes are ignored and `ser_out` keeps its level.
- R7: `irq` is 1 exactly when `rdy_flag` or `idle_flag` is 1, and it stays 1 until both are cleared.
- R8: After reset, `ser_out` is 1 and `rdy_flag`, `idle_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit, 0 = receive (transmitter held clear) |
| wr_en | input | 1 | Host write strobe for the transmit buffer |
| wr_data | input | DATA_W | Byte written into the buffer |
| stat_rd | input | 1 | Host status-read strobe |
| bit_en | input | 1 | One-cycle bit-rate enable |
| ser_out | output | 1 | Serial data out |
| rdy_flag | output | 1 | Buffer can accept the next byte |
| idle_flag | output | 1 | All data and the hang bit have been sent |
| irq | output | 1 | Interrupt, OR of the flags |

## Verification
The hardest situations to reach are the ones where a host write lands in the same cycle as a bit-rate event. One case is a write in the cycle where the hang bit ends, which must block the idle flag. The other is a write in the load cycle, which must leave the data-ready request standing. The random phase pulses `bit_en` on most cycles and writes densely, so these collisions happen often. Directed sequences pin down the plain hang-bit timing and the read-then-write clear order first.

// File: rtl/byte_serial_tx_pkg.sv
package byte_serial_tx_pkg;
  // Top bit of a data word, the next bit to be sent.
  function automatic logic lead_bit(input logic [7:0] w);
    return w[7];
  endfunction
  // Word after one bit has been shifted out.
  function automatic logic [7:0] after_shift(input logic [7:0] w);
    return {w[6:0], 1'b0};
  endfunction
endpackage

// File: rtl/bst_hold_buf.sv
module bst_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (!run) begin
      full <= 1'b0;
    end else begin
      full <= (full & ~take) | wr_en;
      if (wr_en) data <= wr_data;
    end
  end
endmodule

// File: rtl/bst_shifter.sv
module bst_shifter
  import byte_serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              bit_en,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  output logic              load_ev,
  output logic              done_ev,
  output logic              ser_out
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              active_q;
  logic              hang_q;
  logic              empty;
  logic              hang_start;

  assign empty      = (left_q == '0);
  assign load_ev    = run & bit_en & empty & buf_full;
  assign hang_start = run & bit_en & empty & ~buf_full & active_q;
  assign done_ev    = run & bit_en & hang_q & ~buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
      hang_q   <= 1'b0;
      ser_out  <= 1'b1;
    end else if (!run) begin
      left_q   <= '0;
      active_q <= 1'b0;
      hang_q   <= 1'b0;
    end else if (bit_en) begin
      if (load_ev) begin
        ser_out  <= lead_bit(buf_data);
        sh_q     <= after_shift(buf_data);
        left_q   <= CNT_W'(DATA_W - 1);
        active_q <= 1'b1;
        hang_q   <= 1'b0;
      end else if (!empty) begin
        ser_out <= lead_bit(sh_q);
        sh_q    <= after_shift(sh_q);
        left_q  <= left_q - 1'b1;
      end else if (hang_start) begin
        active_q <= 1'b0;
        hang_q   <= 1'b1;
      end else if (done_ev) begin
        hang_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bst_flags.sv
module bst_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wr_en,
  input  logic stat_rd,
  input  logic load_ev,
  input  logic done_ev,
  output logic rdy_flag,
  output logic idle_flag
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_flag  <= 1'b0;
      seen_q    <= 1'b0;
      idle_flag <= 1'b0;
    end else if (!run) begin
      rdy_flag  <= 1'b0;
      seen_q    <= 1'b0;
      idle_flag <= 1'b0;
    end else begin
      if (load_ev) begin
        rdy_flag <= 1'b1;
        seen_q   <= 1'b0;
      end else if (wr_en && seen_q) begin
        rdy_flag <= 1'b0;
        seen_q   <= 1'b0;
      end else if (stat_rd && rdy_flag) begin
        seen_q <= 1'b1;
      end
      if (wr_en)        idle_flag <= 1'b0;
      else if (done_ev) idle_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/byte_serial_tx.sv
module byte_serial_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic              bit_en,
  output logic              ser_out,
  output logic              rdy_flag,
  output logic              idle_flag,
  output logic              irq
);
  logic              wr_ok;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              load_ev;
  logic              done_ev;

  assign wr_ok = wr_en & tx_mode;

  bst_hold_buf #(.DATA_W(DATA_W)) i_buf (
    .clk(clk), .rst_n(rst_n), .run(tx_mode), .wr_en(wr_ok),
    .wr_data(wr_data), .take(load_ev), .full(buf_full), .data(buf_data)
  );

  bst_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .run(tx_mode), .bit_en(bit_en),
    .buf_full(buf_full), .buf_data(buf_data), .load_ev(load_ev),
    .done_ev(done_ev), .ser_out(ser_out)
  );

  bst_flags i_flags (
    .clk(clk), .rst_n(rst_n), .run(tx_mode), .wr_en(wr_ok),
    .stat_rd(stat_rd), .load_ev(load_ev), .done_ev(done_ev),
    .rdy_flag(rdy_flag), .idle_flag(idle_flag)
  );

  assign irq = rdy_flag | idle_flag;
endmodule

// File: rtl/byte_serial_tx_chk.sv
module byte_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_mode,
  input logic wr_en,
  input logic bit_en,
  input logic ser_out,
  input logic rdy_flag,
  input logic idle_flag,
  input logic irq,
  input logic load_ev,
  input logic done_ev
);
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode |=> (!rdy_flag && !idle_flag)); // R6
  AST_WRITE_BLOCKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && wr_en) |=> !idle_flag); // R5
  AST_IDLE_AFTER_HANG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> $past(done_ev)); // R4
  AST_IDLE_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> $stable(ser_out)); // R4
  AST_READY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> rdy_flag); // R2
  AST_READY_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rdy_flag) && $past(tx_mode)) |-> $past(wr_en)); // R3
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(irq)) |-> (rdy_flag || idle_flag)); // R7
endmodule

bind byte_serial_tx byte_serial_tx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .wr_en(wr_en),
  .bit_en(bit_en), .ser_out(ser_out), .rdy_flag(rdy_flag),
  .idle_flag(idle_flag), .irq(irq), .load_ev(load_ev), .done_ev(done_ev)
);

// File: tb/test_byte_serial_tx.sv
module test_byte_serial_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_mode = 1'b0, wr_en = 1'b0, stat_rd = 1'b0, bit_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic ser_out, rdy_flag, idle_flag, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byte_serial_tx #(.DATA_W(8)) i_byte_serial_tx (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .wr_en(wr_en),
    .wr_data(wr_data), .stat_rd(stat_rd), .bit_en(bit_en),
    .ser_out(ser_out), .rdy_flag(rdy_flag), .idle_flag(idle_flag), .irq(irq)
  );

  // Reference model, event-level view of the requirements.
  bit       m_full, m_hang, m_sending, m_rdy, m_read, m_idle, m_out = 1'b1;
  logic [7:0] m_buf;
  logic [7:0] m_word;
  int       m_bits;

  function automatic bit nth_bit(input logic [7:0] b, input int i);
    return b[7 - i];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (!tx_mode) begin
        m_full = 0; m_hang = 0; m_sending = 0; m_bits = 0;
        m_rdy = 0; m_read = 0; m_idle = 0;
      end else begin
        bit ld, fin, w;
        w   = wr_en;
        ld  = bit_en && m_bits == 0 && m_full;
        fin = bit_en && m_hang && !m_full;
        if (ld) begin
          m_word = m_buf; m_out = nth_bit(m_word, 0); m_bits = 7;
          m_sending = 1; m_hang = 0;
        end else if (bit_en && m_bits > 0) begin
          m_out = nth_bit(m_word, 8 - m_bits); m_bits = m_bits - 1;
        end else if (bit_en && m_sending && !m_full) begin
          m_sending = 0; m_hang = 1;
        end else if (fin) m_hang = 0;
        if (ld) begin m_rdy = 1; m_read = 0; end
        else if (w && m_read) begin m_rdy = 0; m_read = 0; end
        else if (stat_rd && m_rdy) m_read = 1;
        if (w) m_idle = 0; else if (fin) m_idle = 1;
        m_full = (m_full && !ld) || w;
        if (w) m_buf = wr_data;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R1", "ser_out", ser_out, m_out);
    check("R2/R3", "rdy_flag", rdy_flag, m_rdy);
    check("R4/R5", "idle_flag", idle_flag, m_idle);
    check("R7", "irq", irq, m_rdy | m_idle);
  endtask

  task automatic cyc(input bit en, input bit wr, input logic [7:0] d, input bit rd);
    bit_en = en; wr_en = wr; wr_data = d; stat_rd = rd;
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "ser_out after reset", ser_out, 1);
    check("R8", "rdy after reset", rdy_flag, 0);
    check("R8", "idle after reset", idle_flag, 0);
    check("R8", "irq after reset", irq, 0);
    rst_n = 1'b1; tx_mode = 1'b1;
    @(negedge clk);
    // R1/R2: one byte, MSB first
    cyc(0, 1, 8'hB4, 0);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      cyc(1, 0, 8'h00, 0);
      got = {got[6:0], ser_out};
      if (i == 0) check("R2", "rdy at load", rdy_flag, 1);
    end
    check("R1", "serial byte", got, 8'hB4);
    // R4: hang bit then idle
    cyc(1, 0, 8'h00, 0);
    check("R4", "idle during hang", idle_flag, 0);
    check("R4", "hang level", ser_out, 0);
    cyc(1, 0, 8'h00, 0);
    check("R4", "idle after hang", idle_flag, 1);
    check("R7", "irq with idle", irq, 1);
    // R3: write without read keeps rdy; R5 write clears idle
    cyc(0, 1, 8'h3C, 0);
    check("R3", "rdy kept without read", rdy_flag, 1);
    check("R5", "idle cleared by write", idle_flag, 0);
    cyc(0, 0, 8'h00, 1);
    cyc(0, 1, 8'h3C, 0);
    check("R3", "rdy cleared read-then-write", rdy_flag, 0);
    // R6: mode low clears and ignores writes
    cyc(1, 0, 8'h00, 0);
    tx_mode = 1'b0;
    cyc(1, 1, 8'hFF, 0);
    check("R6", "rdy in receive mode", rdy_flag, 0);
    tx_mode = 1'b1;
    cyc(1, 0, 8'h00, 0);
    cyc(1, 0, 8'h00, 0);
    check("R6", "no load from ignored write", rdy_flag, 0);
    // Random phase
    for (int n = 0; n < 20000; n++) begin
      if ($urandom_range(0, 199) == 0) tx_mode = ~tx_mode;
      else if (!tx_mode && $urandom_range(0, 9) == 0) tx_mode = 1'b1;
      cyc(($urandom_range(0, 3) != 0), ($urandom_range(0, 11) == 0),
          8'($urandom), ($urandom_range(0, 5) == 0));
    end
    finish_run();
  end
endmodule